// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block builds an output clock from one of up to eleven source clocks. A multiplexer picks the source, and an integer divider running on that source sets the output period. The block is configured through a 32-bit control word, loaded on a plain write strobe in the control clock domain. The divisor arrives on its own port and must be held steady while the generator runs.

Apart from the divide function, the generator has four controls:

- An enable that starts and stops the output only at a pulse boundary.
- A start delay of zero to three source cycles, latched when the enable is raised.
- A nudge bit. Every change of its value makes the output slip by one source cycle.
- An asynchronous kill. It drives the output low at once and clears all generator state.

For odd divisors, a duty-correction option adds a half-cycle stage clocked on the falling edge, so the output high and low times are equal. A status output, brought back into the control domain, shows whether the generator is running.

Top module: `gpclk_gen`

## Requirements
- R1: After reset the control word is all zeros, `clk_out` is low and `enabled` is low.
- R2: Control bits 8:5 select the source: codes 0 to 10 pick `src_clk[code]`, and codes 11 to 15 select a constant low, so the generator never starts and `clk_out` stays low.
- R3: With duty correction off, or with an even divisor, the output period is N source cycles: high for floor(N/2) cycles, then low for the rest. A divisor port value of 0 means N = 65536.
- R4: With a divisor of 1, a running generator passes the selected source clock straight through, including its duty cycle.
- R5: With control bit 12 set and an odd divisor N greater than 1, the output is high for N/2 source cycles and low for N/2 source cycles, using half-cycle resolution. With an even divisor, bit 12 has no effect.
- R6: Setting control bit 10 drives `clk_out` low without waiting for any clock edge and clears the generator. While the bit stays set, no pulse appears and `enabled` falls. Once the bit is cleared, normal operation can resume.
- R7: Control bit 11 starts and stops the generator. Every high pulse, including the first and the last, has the full programmed width, and the output rests low once stopped.
- R8: Control bits 17:16 hold P (0 to 3). P delays the start by P source cycles relative to P = 0, and is latched on the cycle the synchronised enable rises.
- R9: Each change of control bit 20, whether rising or falling, while running holds the divider count for one source cycle. This shifts every later output edge by one source period.
- R10: `enabled` goes high once the generator is running and low once it has stopped, after synchronisation into the control domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control-domain clock |
| ctl_rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Loads `wr_data` into the control word |
| wr_data | input | 32 | Control word value |
| src_clk | input | NUM_SRC | Candidate source clocks |
| div | input | DIV_W | Integer divisor; 0 means 2**DIV_W |
| clk_out | output | 1 | Generated clock |
| enabled | output | 1 | Generator-running status, control domain |

## Verification
The bench measures the high and low widths of `clk_out` for even and odd divisors, for pass-through, and with duty correction. A divider that miscounts the high phase, or that drops the falling-edge stage, shows up as a width that is off by a whole or half source period.

A width watcher checks every pulse around enable and disable. An enable that is not aligned to a pulse boundary would leave a short first or last pulse.

Phase delay is checked by timing the first output edge from a cycle-aligned write, once with a delay of 0 and once with a delay of 3. Nudge is checked by comparing edge times against the pre-nudge grid after each bit change. A detector that reacted only to rising edges would leave the second slip missing.

Kill is applied in the middle of a high pulse, so a synchronous clear would show a late fall. Reserved source codes must neither start the generator nor raise the status.

// File: rtl/gpclk_pkg.sv
`timescale 1ns/1ps
package gpclk_pkg;
   // control word field positions (bit positions are part of the register contract)
   localparam int SEL_LSB   = 5;
   localparam int SEL_W     = 4;
   localparam int KILL_POS  = 10;
   localparam int EN_POS    = 11;
   localparam int DC_POS    = 12;
   localparam int PH_LSB    = 16;
   localparam int PH_W      = 2;
   localparam int NUDGE_POS = 20;

   typedef struct packed {
      logic             nudge;
      logic [PH_W-1:0]  phase;
      logic             dc50;
      logic             en;
      logic             kill;
      logic [SEL_W-1:0] sel;
   } ctl_t;

   function automatic ctl_t decode_ctl(input logic [31:0] w);
      ctl_t c;
      c.sel   = w[SEL_LSB +: SEL_W];
      c.kill  = w[KILL_POS];
      c.en    = w[EN_POS];
      c.dc50  = w[DC_POS];
      c.phase = w[PH_LSB +: PH_W];
      c.nudge = w[NUDGE_POS];
      return c;
   endfunction
endpackage

// File: rtl/gpclk_sync.sv
`timescale 1ns/1ps
module gpclk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpclk_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) ff <= '0;
      else         ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/gpclk_src_mux.sv
`timescale 1ns/1ps
module gpclk_src_mux #(
   parameter int NUM_SRC = 11,
   parameter int SEL_W   = 4
) (
   input  logic [NUM_SRC-1:0] src_clk,
   input  logic [SEL_W-1:0]   sel,
   output logic               clk_sel
);
   localparam int SLOTS = 1 << SEL_W;

   if (NUM_SRC > SLOTS || NUM_SRC < 1) begin : g_bad_count
      $error("gpclk_src_mux: NUM_SRC must be 1..2**SEL_W");
   end

   logic [SLOTS-1:0] slot;

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      if (i < NUM_SRC) begin : g_live
         assign slot[i] = src_clk[i];
      end else begin : g_tied
         assign slot[i] = 1'b0;   // reserved codes: constant low
      end
   end

   assign clk_sel = slot[sel];
endmodule

// File: rtl/gpclk_divider.sv
`timescale 1ns/1ps
module gpclk_divider #(
   parameter int DIV_W       = 16,
   parameter int PHASE_W     = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               arst_n,
   input  logic               en_async,
   input  logic               nudge_async,
   input  logic [PHASE_W-1:0] phase,
   input  logic               dc50,
   input  logic [DIV_W-1:0]   div,
   output logic               clk_out,
   output logic               running
);
   localparam int CNT_W = DIV_W + 1;
   localparam int TAPS  = 1 << PHASE_W;
   localparam logic [CNT_W-1:0] FULL = {1'b1, {DIV_W{1'b0}}};
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   if (DIV_W < 2 || DIV_W > 24) begin : g_bad_div
      $error("gpclk_divider: DIV_W out of range");
   end
   if (PHASE_W < 1 || PHASE_W > 4) begin : g_bad_phase
      $error("gpclk_divider: PHASE_W out of range");
   end

   // ---------------- synchronisers ----------------
   logic en_s, nudge_s;

   gpclk_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
      .clk(clk), .arst_n(arst_n), .d(en_async), .q(en_s));
   gpclk_sync #(.STAGES(SYNC_STAGES)) u_ndg_sync (
      .clk(clk), .arst_n(arst_n), .d(nudge_async), .q(nudge_s));

   // ---------------- enable delay line ----------------
   logic               en_q, nudge_q, live_q;
   logic [PHASE_W-1:0] ph_lat, ph_sel;
   logic [TAPS-1:0]    taps;
   logic               en_rise, en_tap, nudge_hit;

   assign taps[0] = en_s;
   for (genvar t = 1; t < TAPS; t++) begin : g_dly
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) taps[t] <= 1'b0;
         else         taps[t] <= taps[t-1];
      end
   end

   assign en_rise   = en_s & ~en_q;
   assign ph_sel    = en_rise ? phase : ph_lat;   // phase sampled only on rise
   assign en_tap    = taps[ph_sel];
   assign nudge_hit = nudge_s ^ nudge_q;          // either edge of nudge

   // ---------------- divider ----------------
   logic [CNT_W-1:0] divn, hi_len, cnt, cnt_nx;
   logic             run, run_nx, out_q, at_end, bypass, dc_on;
   logic             run_neg, out_neg;

   assign divn   = (div == '0) ? FULL : {1'b0, div};
   assign hi_len = divn >> 1;
   assign at_end = (cnt == divn - ONE);
   assign bypass = (divn == ONE);
   assign dc_on  = dc50 & divn[0] & ~bypass;

   always_comb begin
      run_nx = run;
      cnt_nx = cnt;
      if (!run) begin
         if (en_tap) begin
            run_nx = 1'b1;
            cnt_nx = '0;
         end
      end else if (nudge_hit) begin
         cnt_nx = cnt;                  // slip one input cycle
      end else if (at_end) begin
         cnt_nx = '0;
         if (!en_tap) run_nx = 1'b0;   // stop only at end of low phase
      end else begin
         cnt_nx = cnt + ONE;
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         en_q    <= 1'b0;
         nudge_q <= 1'b0;
         live_q  <= 1'b0;
         ph_lat  <= '0;
         run     <= 1'b0;
         cnt     <= '0;
         out_q   <= 1'b0;
      end else begin
         en_q    <= en_s;
         nudge_q <= nudge_s;
         live_q  <= 1'b1;
         if (en_rise) ph_lat <= phase;
         run     <= run_nx;
         cnt     <= cnt_nx;
         out_q   <= run_nx & (cnt_nx < hi_len);
      end
   end

   // falling-edge stage: half-cycle extension and pass-through gate
   always_ff @(negedge clk or negedge arst_n) begin
      if (!arst_n) begin
         run_neg <= 1'b0;
         out_neg <= 1'b0;
      end else begin
         run_neg <= run;
         out_neg <= out_q;
      end
   end

   always_comb begin
      if (bypass)     clk_out = clk & run_neg;
      else if (dc_on) clk_out = out_q | out_neg;
      else            clk_out = out_q;
   end

   assign running = run;

   // ---------------- assertions ----------------
   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!arst_n)
      run |-> (cnt < divn));                                   // R3
   AST_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!arst_n)
      (live_q && $fell(run)) |-> $past(at_end));               // R7
   AST_NUDGE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!arst_n)
      (run && nudge_hit) |=> $stable(cnt));                    // R9
   AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!arst_n)
      (run && !en_rise) |=> $stable(ph_lat));                  // R8
endmodule

// File: rtl/gpclk_gen.sv
`timescale 1ns/1ps
module gpclk_gen
   import gpclk_pkg::*;
#(
   parameter int NUM_SRC     = 11,
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic               ctl_clk,
   input  logic               ctl_rst_n,
   input  logic               wr_en,
   input  logic [31:0]        wr_data,
   input  logic [NUM_SRC-1:0] src_clk,
   input  logic [DIV_W-1:0]   div,
   output logic               clk_out,
   output logic               enabled
);
   ctl_t ctl_q;
   logic clk_sel, gen_rst_n, gen_out, gen_run;

   always_ff @(posedge ctl_clk or negedge ctl_rst_n) begin
      if (!ctl_rst_n)  ctl_q <= '0;
      else if (wr_en)  ctl_q <= decode_ctl(wr_data);
   end

   // kill acts as an asynchronous clear of the whole generated domain
   assign gen_rst_n = ctl_rst_n & ~ctl_q.kill;

   gpclk_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
      .src_clk(src_clk), .sel(ctl_q.sel), .clk_sel(clk_sel));

   gpclk_divider #(.DIV_W(DIV_W), .PHASE_W(PH_W), .SYNC_STAGES(SYNC_STAGES)) u_div (
      .clk(clk_sel), .arst_n(gen_rst_n), .en_async(ctl_q.en),
      .nudge_async(ctl_q.nudge), .phase(ctl_q.phase), .dc50(ctl_q.dc50),
      .div(div), .clk_out(gen_out), .running(gen_run));

   assign clk_out = gen_out & ~ctl_q.kill;

   gpclk_sync #(.STAGES(SYNC_STAGES)) u_stat_sync (
      .clk(ctl_clk), .arst_n(ctl_rst_n), .d(gen_run), .q(enabled));

   AST_KILL_FORCES_LOW: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
      ctl_q.kill |-> !clk_out);                                // R6
endmodule

// File: tb/sim_gpclk_gen.sv
`timescale 1ns/1ps
module sim_gpclk_gen;
   localparam int NSRC = 11;
   localparam int DW   = 16;

   logic             ctl_clk = 1'b0;
   logic             ctl_rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [31:0]      wr_data = '0;
   logic [NSRC-1:0]  src_clk;
   logic [DW-1:0]    div = '0;
   logic             clk_out, enabled;

   always #4 ctl_clk = ~ctl_clk;   // 125 MHz

   // source k has period 20+4k ns
   for (genvar k = 0; k < NSRC; k++) begin : g_src
      logic c = 1'b0;
      always #(10 + 2*k) c = ~c;
      assign src_clk[k] = c;
   end

   gpclk_gen #(.NUM_SRC(NSRC), .DIV_W(DW), .SYNC_STAGES(2)) u0 (
      .ctl_clk(ctl_clk), .ctl_rst_n(ctl_rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .src_clk(src_clk), .div(div), .clk_out(clk_out), .enabled(enabled));

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   function automatic logic [31:0] mk(input int sel, input bit kill, input bit en,
                                      input bit dc, input int ph, input bit ndg);
      logic [31:0] v;
      v = '0;
      v[8:5]   = sel[3:0];
      v[10]    = kill;
      v[11]    = en;
      v[12]    = dc;
      v[17:16] = ph[1:0];
      v[20]    = ndg;
      return v;
   endfunction

   task automatic wr(input logic [31:0] v);
      @(negedge ctl_clk);
      wr_en   = 1'b1;
      wr_data = v;
      @(negedge ctl_clk);
      wr_en   = 1'b0;
   endtask

   // ---------------- scoreboard ----------------
   typedef struct {
      longint hi;
      longint lo;
      string  req;
   } exp_t;
   exp_t sbq[$];

   initial begin
      forever begin
         exp_t   e;
         longint t0, t1, t2;
         while (sbq.size() == 0) @(posedge ctl_clk);
         @(posedge clk_out); t0 = $time;
         @(negedge clk_out); t1 = $time;
         @(posedge clk_out); t2 = $time;
         e = sbq.pop_front();
         chk((t1 - t0) == e.hi, e.req, t1 - t0, e.hi);
         chk((t2 - t1) == e.lo, e.req, t2 - t1, e.lo);
      end
   end

   // pulse-width watcher: no shortened pulse at start or stop (R7)
   longint exp_hi = 0;
   longint last_rise = 0;
   int     rise_cnt = 0;
   always @(posedge clk_out) begin
      last_rise = $time;
      rise_cnt++;
   end
   always @(negedge clk_out) begin
      if (exp_hi != 0) chk(($time - last_rise) == exp_hi, "R7", $time - last_rise, exp_hi);
   end

   // driver: configure, push expected shape, stop cleanly
   task automatic shape(input int sel, input int d, input bit dc,
                        input longint hi, input longint lo, input string req);
      div    = DW'(d);
      exp_hi = hi;
      wr(mk(sel, 1'b0, 1'b1, dc, 0, 1'b0));
      wait (enabled == 1'b1);
      chk(enabled == 1'b1, "R10", enabled, 1);
      sbq.push_back('{hi, lo, req});
      while (sbq.size() != 0) @(posedge ctl_clk);
      wr(mk(sel, 1'b0, 1'b0, dc, 0, 1'b0));
      wait (enabled == 1'b0);
      #200;
      chk(clk_out == 1'b0, "R7", clk_out, 0);
      chk(enabled == 1'b0, "R10", enabled, 0);
      exp_hi = 0;
   endtask

   task automatic start_latency(input int ph, output longint lat);
      longint tw;
      div = DW'(4);
      @(negedge ctl_clk);
      while (($time % 40) != 8) @(negedge ctl_clk);
      wr_en   = 1'b1;
      wr_data = mk(0, 1'b0, 1'b1, 1'b0, ph, 1'b0);
      tw = $time + 4;
      @(negedge ctl_clk);
      wr_en = 1'b0;
      @(posedge clk_out);
      lat = $time - tw;
      wr(mk(0, 1'b0, 1'b0, 1'b0, ph, 1'b0));
      wait (enabled == 1'b0);
      #300;
   endtask

   // watchdog
   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
   end

   initial begin
      longint l0, l1, l3, t0, t1, t2;
      int     rc;

      #50;
      @(negedge ctl_clk);
      ctl_rst_n = 1'b1;
      #40;
      chk(clk_out == 1'b0, "R1", clk_out, 0);
      chk(enabled == 1'b0, "R1", enabled, 0);

      // R3: divide ratios
      shape(0, 4, 1'b0, 40, 40, "R3");
      shape(0, 5, 1'b0, 40, 60, "R3");
      // R2: highest source code, period 60
      shape(10, 7, 1'b0, 180, 240, "R2");
      // R5: odd with correction, and even where the flag has no effect
      shape(3, 5, 1'b1, 80, 80, "R5");
      shape(1, 6, 1'b1, 72, 72, "R5");
      // R4: pass-through
      shape(2, 1, 1'b0, 14, 14, "R4");
      shape(4, 1, 1'b1, 18, 18, "R4");

      // R2: reserved code never starts
      div = DW'(2);
      rc = rise_cnt;
      wr(mk(12, 1'b0, 1'b1, 1'b0, 0, 1'b0));
      #1000;
      chk(rise_cnt == rc, "R2", rise_cnt - rc, 0);
      chk(enabled == 1'b0, "R2", enabled, 0);
      wr(mk(12, 1'b0, 1'b0, 1'b0, 0, 1'b0));
      wr(mk(0, 1'b0, 1'b0, 1'b0, 0, 1'b0));
      #200;

      // R8: phase delay, source 0 period 20
      start_latency(0, l0);
      start_latency(1, l1);
      start_latency(3, l3);
      chk((l1 - l0) == 20, "R8", l1 - l0, 20);
      chk((l3 - l0) == 60, "R8", l3 - l0, 60);

      // R9: nudge on both edges, div 4 period 80
      div = DW'(4);
      wr(mk(0, 1'b0, 1'b1, 1'b0, 0, 1'b0));
      wait (enabled == 1'b1);
      @(posedge clk_out); t0 = $time;
      wr(mk(0, 1'b0, 1'b1, 1'b0, 0, 1'b1));
      #400;
      @(posedge clk_out); t1 = $time;
      chk(((t1 - t0) % 80) == 20, "R9", (t1 - t0) % 80, 20);
      wr(mk(0, 1'b0, 1'b1, 1'b0, 0, 1'b0));
      #400;
      @(posedge clk_out); t2 = $time;
      chk(((t2 - t0) % 80) == 40, "R9", (t2 - t0) % 80, 40);

      // R6: kill in the middle of a high pulse
      @(posedge clk_out);
      @(negedge ctl_clk);
      wr_en   = 1'b1;
      wr_data = mk(0, 1'b1, 1'b1, 1'b0, 0, 1'b0);
      @(posedge ctl_clk);
      #1;
      chk(clk_out == 1'b0, "R6", clk_out, 0);
      @(negedge ctl_clk);
      wr_en = 1'b0;
      #100;
      chk(enabled == 1'b0, "R6", enabled, 0);
      rc = rise_cnt;
      #600;
      chk(rise_cnt == rc, "R6", rise_cnt - rc, 0);
      wr(mk(0, 1'b0, 1'b0, 1'b0, 0, 1'b0));
      #200;
      shape(0, 4, 1'b0, 40, 40, "R6");

      summary();
      $finish;
   end
endmodule